// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block sequences the calibration steps of a sampling converter. Software starts a sequence by writing a 3-bit mode code. The block then counts output-rate periods, which arrive as one-cycle pulses on a conversion-tick input. At the right periods it pulses a zero-scale capture strobe or a full-scale capture strobe. It returns the mode readback to 000 when the calibration part of the sequence is over. It drives an active-low data-ready output once the first normal conversion after calibration has passed through the result pipeline.

Each calibration code has its own pattern of strobes and its own two completion points. Reading 000 back from the mode field means the calibration is over. Data-ready falling later means a valid, correctly scaled result is available. Code 000 is plain conversion with one ready per period. Code 101 is background calibration: it repeats a zero-scale step and a conversion forever and keeps its code. A low level on the hold input freezes the sequencer, so that calibration coefficients can be accessed safely. A code written while a calibration is running is kept and started when that calibration finishes.

Top module: `cal_sequencer`

## Requirements
- R1: After reset, the mode readback is 000, rdy_n is 1 and both capture strobes are 0.
- R2: In code 000 with no sequence pending, each counted tick drives rdy_n low from the clock edge that samples the tick. A data_rd pulse drives rdy_n high again from the next edge.
- R3: Codes 001 and 100 pulse zs_cap on the 3rd counted tick and fs_cap on the 6th. They clear the mode readback to 000 on the 6th tick, and drive rdy_n low PIPE_DLY clock cycles after the edge that samples the 9th tick.
- R4: Code 010 pulses zs_cap and code 011 pulses fs_cap on the 3rd counted tick. Both clear the mode on that tick, and drive rdy_n low PIPE_DLY cycles after the 4th tick.
- R5: Code 110 pulses zs_cap and code 111 pulses fs_cap on the 3rd counted tick. Both clear the mode on that tick, and drive rdy_n low PIPE_DLY cycles after the 6th tick.
- R6: Code 101 keeps the mode readback at 101. It counts ticks in cycles of six, pulses zs_cap on the 3rd tick of each cycle and drives rdy_n low on the 6th, with no pipeline wait.
- R7: While hold_n is 0, ticks are not counted, the pipeline wait does not advance, and no strobe or ready edge is produced.
- R8: An accepted mode write sets rdy_n to 1 and restarts tick counting from zero. This includes a write during the pipeline wait, which cancels that wait.
- R9: A mode write while the readback holds one of the codes 001, 010, 011, 100, 110 or 111 does not change the readback. The last such code is started on the tick that would have cleared the mode, and the readback goes straight to it.
- R10: Strobes are single-cycle pulses, change only on an edge that samples a counted tick, and never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_tick | input | 1 | One-cycle pulse per output-rate period |
| hold_n | input | 1 | Low suspends counting and the pipeline wait |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 3 | Mode code written |
| data_rd | input | 1 | Data register read strobe |
| mode_q | output | 3 | Mode readback |
| zs_cap | output | 1 | Zero-scale capture strobe |
| fs_cap | output | 1 | Full-scale capture strobe |
| rdy_n | output | 1 | Active-low data ready |

## Verification
The bench builds the block with PIPE_DLY set to 12 instead of 2000. This lets every code run to its ready point within a few dozen cycles, with the exact ready cycle predicted. The short wait also leaves room to freeze the pipeline with hold_n for a known number of cycles and check the shifted ready time. It also leaves room to interrupt the wait with a new mode write and confirm that the old ready never appears.

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
  parameter int PIPE_DLY = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_tick,
  input  logic       hold_n,
  input  logic       mode_wr,
  input  logic [2:0] mode_in,
  input  logic       data_rd,
  output logic [2:0] mode_q,
  output logic       zs_cap,
  output logic       fs_cap,
  output logic       rdy_n
);
  localparam int PW = $clog2(PIPE_DLY + 1);
  localparam logic [2:0] BG = 3'd5;

  logic [2:0]    seq_m, pend;
  logic          pend_v, act, pipe_on;
  logic [3:0]    cnt, cnt_nx, clr_at, rdy_at, zs_at, fs_at;
  logic [PW-1:0] pcnt;

  always_comb begin
    case (seq_m)
      3'd1, 3'd4: {clr_at, rdy_at, zs_at, fs_at} = {4'd6, 4'd9, 4'd3, 4'd6};
      3'd2:       {clr_at, rdy_at, zs_at, fs_at} = {4'd3, 4'd4, 4'd3, 4'd0};
      3'd3:       {clr_at, rdy_at, zs_at, fs_at} = {4'd3, 4'd4, 4'd0, 4'd3};
      3'd5:       {clr_at, rdy_at, zs_at, fs_at} = {4'd0, 4'd6, 4'd3, 4'd0};
      3'd6:       {clr_at, rdy_at, zs_at, fs_at} = {4'd3, 4'd6, 4'd3, 4'd0};
      3'd7:       {clr_at, rdy_at, zs_at, fs_at} = {4'd3, 4'd6, 4'd0, 4'd3};
      default:    {clr_at, rdy_at, zs_at, fs_at} = '0;
    endcase
  end

  wire       tk       = conv_tick && hold_n;
  wire       bg       = (seq_m == BG);
  wire       busy     = act && (mode_q != 3'd0);
  wire       wr_busy  = mode_wr && busy;
  wire       pv       = pend_v || wr_busy;
  wire [2:0] pm       = wr_busy ? mode_in : pend;
  wire       clr_hit  = tk && busy && (cnt_nx == clr_at);
  wire       start_go = (mode_wr && !busy) || (clr_hit && pv);
  wire [2:0] start_m  = (mode_wr && !busy) ? mode_in : pm;
  wire       step     = tk && (act || bg);

  assign cnt_nx = (cnt == 4'd15) ? cnt : cnt + 4'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      seq_m   <= '0;
      pend    <= '0;
      pend_v  <= 1'b0;
      act     <= 1'b0;
      pipe_on <= 1'b0;
      cnt     <= '0;
      pcnt    <= '0;
      zs_cap  <= 1'b0;
      fs_cap  <= 1'b0;
      rdy_n   <= 1'b1;
    end else begin
      zs_cap <= step && (cnt_nx == zs_at);
      fs_cap <= step && (cnt_nx == fs_at);
      if (data_rd) rdy_n <= 1'b1;
      if (wr_busy) begin
        pend   <= mode_in;
        pend_v <= 1'b1;
      end
      if (start_go) begin
        mode_q  <= start_m;
        seq_m   <= start_m;
        cnt     <= '0;
        act     <= (start_m != 3'd0) && (start_m != BG);
        pipe_on <= 1'b0;
        pend_v  <= 1'b0;
        rdy_n   <= 1'b1;
      end else begin
        if (tk) begin
          if (bg) begin
            cnt <= (cnt_nx == 4'd6) ? 4'd0 : cnt_nx;
            if (cnt_nx == 4'd6) rdy_n <= 1'b0;
          end else if (act) begin
            cnt <= cnt_nx;
            if (cnt_nx == clr_at) mode_q <= 3'd0;
            if (cnt_nx == rdy_at) begin
              pipe_on <= 1'b1;
              pcnt    <= PW'(PIPE_DLY - 1);
            end
          end else begin
            rdy_n <= 1'b0;
          end
        end
        if (pipe_on && hold_n) begin
          if (pcnt == '0) begin
            rdy_n   <= 1'b0;
            act     <= 1'b0;
            pipe_on <= 1'b0;
          end else begin
            pcnt <= pcnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

module cal_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_tick,
  input logic       hold_n,
  input logic       mode_wr,
  input logic [2:0] mode_q,
  input logic       zs_cap,
  input logic       fs_cap,
  input logic       rdy_n
);
  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(zs_cap && fs_cap));
  a_r10_strobe_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (zs_cap || fs_cap) |-> $past(conv_tick && hold_n));
  a_r8_write_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> rdy_n);
  a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !mode_wr) |=> ($stable(mode_q) && !zs_cap && !fs_cap));
  a_r7_no_ready_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(hold_n));
  a_r9_busy_write_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_q != 3'd0 && mode_q != 3'd5 && !(conv_tick && hold_n)) |=> $stable(mode_q));
endmodule

bind cal_sequencer cal_sequencer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .hold_n(hold_n), .mode_wr(mode_wr),
  .mode_q(mode_q), .zs_cap(zs_cap), .fs_cap(fs_cap), .rdy_n(rdy_n)
);

// File: tb/cal_sequencer_tb.sv
module cal_sequencer_tb_top;
  localparam int P = 12;

  logic clk = 1'b0, rst_n = 1'b0, conv_tick = 1'b0, hold_n = 1'b1;
  logic mode_wr = 1'b0, data_rd = 1'b0;
  logic [2:0] mode_in = '0;
  logic [2:0] mode_q;
  logic zs_cap, fs_cap, rdy_n;

  always #2.5 clk = ~clk;

  cal_sequencer #(.PIPE_DLY(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .hold_n(hold_n),
    .mode_wr(mode_wr), .mode_in(mode_in), .data_rd(data_rd),
    .mode_q(mode_q), .zs_cap(zs_cap), .fs_cap(fs_cap), .rdy_n(rdy_n)
  );

  typedef struct packed {
    logic [7:0]  kind;
    logic [2:0]  val;
    logic [31:0] cyc;
    logic [7:0]  req;
  } ev_t;

  ev_t q[$];
  int cyc = 0, compared = 0, mismatched = 0;
  logic started = 1'b0, done = 1'b0;
  logic [2:0] pm = '0, cur_mode = '0;
  logic pr = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input logic [7:0] k, input logic [2:0] v, input int c, input int r);
    ev_t e;
    e.kind = k; e.val = v; e.cyc = c; e.req = r[7:0];
    q.push_back(e);
  endtask

  task automatic find(input logic [7:0] k, input logic [2:0] v);
    int idx = -1;
    for (int i = 0; i < q.size(); i++)
      if (q[i].kind == k && q[i].val == v && q[i].cyc == cyc) begin idx = i; break; end
    if (idx >= 0) begin
      compared++;
      $display("  ok R%0d event %c=%0d at cycle %0d", q[idx].req, k, v, cyc);
      q.delete(idx);
    end else begin
      mismatched++;
      $display("FAIL unexpected event: actual %c=%0d at cycle %0d, expected none", k, v, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      if (mode_q !== pm) find("M", mode_q);
      if (zs_cap) find("Z", 3'd0);
      if (fs_cap) find("F", 3'd0);
      if (pr && !rdy_n) find("D", 3'd0);
      if (zs_cap && fs_cap) begin
        mismatched++;
        $display("FAIL R10 strobes together: actual 1/1 expected at most one");
      end
      pm = mode_q;
      pr = rdy_n;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick;
    conv_tick = 1'b1;
    @(negedge clk) conv_tick = 1'b0;
  endtask

  task automatic raw_wr(input logic [2:0] m);
    mode_wr = 1'b1; mode_in = m;
    @(negedge clk) mode_wr = 1'b0;
  endtask

  task automatic wr_mode(input logic [2:0] m);
    if (m != cur_mode) push("M", m, cyc + 1, 8);
    cur_mode = m;
    raw_wr(m);
    chk("R8 ready high after write", rdy_n, 1);
  endtask

  task automatic read_data;
    data_rd = 1'b1;
    @(negedge clk) data_rd = 1'b0;
    chk("R8 ready high after read", rdy_n, 1);
  endtask

  task automatic run_ticks(input int n, input int clr, input int rdy, input int zs, input int fs, input int r);
    for (int k = 1; k <= n; k++) begin
      int e;
      idle(3);
      e = cyc + 1;
      if (k == zs) push("Z", 3'd0, e, r);
      if (k == fs) push("F", 3'd0, e, r);
      if (k == clr) begin push("M", 3'd0, e, r); cur_mode = 3'd0; end
      if (k == rdy) push("D", 3'd0, e + P, r);
      pulse_tick();
    end
  endtask

  task automatic settle;
    idle(P + 4);
    read_data();
  endtask

  initial begin
    int e;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    started = 1'b1;
    // R1 reset state
    chk("R1 mode", mode_q, 0);
    chk("R1 rdy_n", rdy_n, 1);
    chk("R1 strobes", {zs_cap, fs_cap}, 0);

    // R2 normal conversion
    for (int k = 0; k < 3; k++) begin
      idle(2);
      push("D", 3'd0, cyc + 1, 2);
      pulse_tick();
      chk("R2 ready low after tick", rdy_n, 0);
      read_data();
    end

    // R3 codes 001 and 100
    wr_mode(3'd1); run_ticks(9, 6, 9, 3, 6, 3); settle();
    wr_mode(3'd4); run_ticks(9, 6, 9, 3, 6, 3); settle();
    chk("R3 mode cleared", mode_q, 0);

    // R4 codes 010 and 011
    wr_mode(3'd2); run_ticks(4, 3, 4, 3, 0, 4); settle();
    wr_mode(3'd3); run_ticks(4, 3, 4, 0, 3, 4); settle();

    // R5 codes 110 and 111
    wr_mode(3'd6); run_ticks(6, 3, 6, 3, 0, 5); settle();
    wr_mode(3'd7); run_ticks(6, 3, 6, 0, 3, 5); settle();

    // R6 background calibration
    wr_mode(3'd5);
    for (int k = 1; k <= 12; k++) begin
      idle(2);
      e = cyc + 1;
      if (k % 6 == 3) push("Z", 3'd0, e, 6);
      if (k % 6 == 0) push("D", 3'd0, e, 6);
      pulse_tick();
      if (k % 6 == 0) read_data();
    end
    chk("R6 mode kept", mode_q, 5);
    wr_mode(3'd0);

    // R7 hold freezes ticks and pipeline
    wr_mode(3'd2);
    run_ticks(2, 3, 4, 3, 0, 7);
    hold_n = 1'b0;
    pulse_tick();
    idle(2);
    chk("R7 mode during hold", mode_q, 2);
    hold_n = 1'b1;
    idle(2);
    e = cyc + 1;
    push("Z", 3'd0, e, 7); push("M", 3'd0, e, 7); cur_mode = 3'd0;
    pulse_tick();
    idle(3);
    e = cyc + 1;
    push("D", 3'd0, e + P + 5, 7);
    pulse_tick();
    hold_n = 1'b0;
    idle(5);
    hold_n = 1'b1;
    settle();

    // R8 write during pipeline wait cancels old ready
    wr_mode(3'd3);
    run_ticks(4, 3, 99, 0, 3, 8);
    idle(3);
    wr_mode(3'd6);
    run_ticks(6, 3, 6, 3, 0, 8);
    settle();

    // R9 deferred write, latest wins
    wr_mode(3'd1);
    run_ticks(2, 99, 99, 99, 99, 9);
    raw_wr(3'd3);
    chk("R9 mode unchanged by busy write", mode_q, 1);
    raw_wr(3'd7);
    chk("R9 ready stays high", rdy_n, 1);
    for (int k = 3; k <= 6; k++) begin
      idle(3);
      e = cyc + 1;
      if (k == 3) push("Z", 3'd0, e, 9);
      if (k == 6) begin push("F", 3'd0, e, 9); push("M", 3'd7, e, 9); cur_mode = 3'd7; end
      pulse_tick();
    end
    chk("R9 pending code started", mode_q, 7);
    run_ticks(6, 3, 6, 0, 3, 9);
    settle();

    idle(4);
    foreach (q[i]) begin
      mismatched++;
      $display("FAIL R%0d missing event: actual none expected %c=%0d at cycle %0d",
               q[i].req, q[i].kind, q[i].val, q[i].cyc);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule